// File: doc/BRIEF.md
# Per-Pin Interrupt Condition Detector

This block watches a port of asynchronous input pins and turns selected pin conditions into latched interrupt flags. Every pin has its own control word, and a 4-bit condition code in that word picks how the pin is watched. It can be off, active while the pin is low, active while it is high, or triggered by a rising edge, a falling edge or either edge. Pins pass through a multi-stage synchroniser before any detection is done.

A detected condition sets that pin's bit in a shared status word. Software clears a bit by writing 1 to it; writing 0 leaves the bit alone. All status bits are ORed into one interrupt request line for the processor. Access is through a plain 32-bit register bus with a single-cycle write strobe and combinational read data. A level condition keeps setting its flag for as long as the level lasts, so a clear only takes effect once the pin has left the active level. Edge history keeps updating while a pin is disabled, so enabling a pin never reports an edge that happened earlier.

Top module: `pinirq_ctrl`

## Requirements
- R1: After reset every pin condition code is 0, every status bit is 0 and `irq_o` is low.
- R2: The control word for pin n sits at byte address 4*n. The condition code is held in bits 19:16. Those four bits read back as written, and every other bit of the word reads 0.
- R3: Code 0x0 and every code not listed in R4 to R8 set no flag, whatever the pin does.
- R4: Code 0x8 sets the pin's flag in every cycle the synchronised pin is 0, so a write-1 clear does not take effect while the pin stays low.
- R5: Code 0xC sets the pin's flag in every cycle the synchronised pin is 1.
- R6: Code 0x9 sets the flag on a 0-to-1 transition only.
- R7: Code 0xA sets the flag on a 1-to-0 transition only.
- R8: Code 0xB sets the flag on either transition.
- R9: The status word is at byte address 0xA0, with bit n belonging to pin n. Writing 1 to a bit clears it, writing 0 leaves it unchanged, and writing all ones clears every flag.
- R10: If an event and a write-1 clear reach the same flag in the same cycle, the flag stays set.
- R11: `irq_o` is high exactly when at least one status bit is set.
- R12: Edge history follows the pin while the pin is disabled, so enabling an edge code after the pin has changed raises no flag.
- R13: A pin change applied before clock edge k shows in the status word after edge k+SYNC_STAGES, and not before.
- R14: Writing 0 to a pin's control word stops new flags for that pin and leaves a pending flag set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pins_i | input | NPINS | Asynchronous pin levels |
| bus_wr_i | input | 1 | Write strobe, one cycle per write |
| bus_addr_i | input | ADDR_W | Byte address |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data for `bus_addr_i`, combinational |
| irq_o | output | 1 | Combined interrupt request |

## Verification
The bench builds the block with its defaults: 32 pins, a two-stage synchroniser and an 8-bit address. With 32 pins the top control word at 0x7C and the status word at 0xA0 both sit in one address map, and every status bit position up to 31 can be reached. With two synchroniser stages the three-cycle latency of R13 can be pinned to an exact cycle. Because of that exact timing, a clear write can be placed in the very cycle an edge event is live, which is the case R10 needs.

// File: rtl/pinirq_pkg.sv
package pinirq_pkg;

  localparam int COND_W   = 4;
  localparam int COND_LSB = 16;

  typedef enum logic [COND_W-1:0] {
    COND_OFF  = 4'h0,
    COND_LOW  = 4'h8,
    COND_RISE = 4'h9,
    COND_FALL = 4'hA,
    COND_BOTH = 4'hB,
    COND_HIGH = 4'hC
  } cond_e;

  // Event rule for one pin: cur is the present synchronised sample,
  // prev the sample one cycle older.
  function automatic logic cond_hit(logic [COND_W-1:0] code, logic cur, logic prev);
    logic hit;
    case (code)
      COND_LOW:  hit = ~cur;
      COND_HIGH: hit = cur;
      COND_RISE: hit = cur & ~prev;
      COND_FALL: hit = ~cur & prev;
      COND_BOTH: hit = cur ^ prev;
      default:   hit = 1'b0;
    endcase
    return hit;
  endfunction

endpackage

// File: rtl/pinirq_sync.sv
module pinirq_sync #(
  parameter int NPINS  = 32,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NPINS-1:0] async_i,
  output logic [NPINS-1:0] sync_o
);

  logic [NPINS-1:0] stage_q [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stage_q[0] <= '0;
    else        stage_q[0] <= async_i;
  end

  for (genvar s = 1; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stage_q[s] <= '0;
      else        stage_q[s] <= stage_q[s-1];
    end
  end

  assign sync_o = stage_q[STAGES-1];

endmodule

// File: rtl/pinirq_detect.sv
module pinirq_detect
  import pinirq_pkg::*;
#(
  parameter int NPINS = 32
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic [NPINS-1:0]             cur_i,
  input  logic [NPINS-1:0][COND_W-1:0] code_i,
  output logic [NPINS-1:0]             evt_o
);

  // Previous sample always tracks, independent of the code.
  logic [NPINS-1:0] prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= '0;
    else        prev_q <= cur_i;
  end

  for (genvar i = 0; i < NPINS; i++) begin : g_pin
    assign evt_o[i] = cond_hit(code_i[i], cur_i[i], prev_q[i]);

    // R6
    rise_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (code_i[i] == COND_RISE && evt_o[i]) |-> (cur_i[i] && !prev_q[i]));
  end

  // R12
  prev_tracks_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (prev_q == $past(cur_i)));

endmodule

// File: rtl/pinirq_flags.sv
module pinirq_flags #(
  parameter int NPINS = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NPINS-1:0] evt_i,
  input  logic [NPINS-1:0] clr_i,
  output logic [NPINS-1:0] flags_o
);

  logic [NPINS-1:0] flags_q;

  // Set wins over clear.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flags_q <= '0;
    else        flags_q <= (flags_q & ~clr_i) | evt_i;
  end

  assign flags_o = flags_q;

  // R9
  clear_takes_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|(clr_i & ~evt_i)) |=> ((flags_q & $past(clr_i & ~evt_i)) == '0));

  // R10
  event_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|evt_i) |=> ((flags_q & $past(evt_i)) == $past(evt_i)));

endmodule

// File: rtl/pinirq_ctrl.sv
module pinirq_ctrl
  import pinirq_pkg::*;
#(
  parameter int               NPINS       = 32,
  parameter int               SYNC_STAGES = 2,
  parameter int               ADDR_W      = 8,
  parameter logic [ADDR_W-1:0] STATUS_ADDR = 8'hA0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NPINS-1:0]  pins_i,
  input  logic              bus_wr_i,
  input  logic [ADDR_W-1:0] bus_addr_i,
  input  logic [31:0]       bus_wdata_i,
  output logic [31:0]       bus_rdata_o,
  output logic              irq_o
);

  localparam int PIN_W = (NPINS > 1) ? $clog2(NPINS) : 1;
  localparam int IDX_W = ADDR_W - 2;

  logic [NPINS-1:0]             pin_s;
  logic [NPINS-1:0][COND_W-1:0] code_q;
  logic [NPINS-1:0]             evt;
  logic [NPINS-1:0]             clr;
  logic [NPINS-1:0]             flags;
  logic [IDX_W-1:0]             word_idx;
  logic [PIN_W-1:0]             pin_sel;
  logic                         ctl_hit;
  logic                         status_hit;
  logic                         any_event;

  // Address decode
  assign word_idx   = bus_addr_i[ADDR_W-1:2];
  assign pin_sel    = word_idx[PIN_W-1:0];
  assign ctl_hit    = (bus_addr_i[1:0] == 2'b00) && (32'(word_idx) < NPINS);
  assign status_hit = (bus_addr_i == STATUS_ADDR);

  pinirq_sync #(.NPINS(NPINS), .STAGES(SYNC_STAGES)) u_sync (
    .clk    (clk),
    .rst_n  (rst_n),
    .async_i(pins_i),
    .sync_o (pin_s)
  );

  // Per-pin condition codes
  for (genvar i = 0; i < NPINS; i++) begin : g_ctl
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        code_q[i] <= COND_OFF;
      else if (bus_wr_i && ctl_hit && (32'(pin_sel) == i))
        code_q[i] <= bus_wdata_i[COND_LSB +: COND_W];
    end
  end

  pinirq_detect #(.NPINS(NPINS)) u_detect (
    .clk   (clk),
    .rst_n (rst_n),
    .cur_i (pin_s),
    .code_i(code_q),
    .evt_o (evt)
  );

  assign clr = (bus_wr_i && status_hit) ? bus_wdata_i[NPINS-1:0] : '0;

  pinirq_flags #(.NPINS(NPINS)) u_flags (
    .clk    (clk),
    .rst_n  (rst_n),
    .evt_i  (evt),
    .clr_i  (clr),
    .flags_o(flags)
  );

  always_comb begin
    bus_rdata_o = '0;
    if (ctl_hit)
      bus_rdata_o[COND_LSB +: COND_W] = code_q[pin_sel];
    else if (status_hit)
      bus_rdata_o = 32'(flags);
  end

  assign irq_o     = |flags;
  assign any_event = |evt;

  // R11
  irq_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_o) |-> $past(any_event));

  // R9
  clear_all_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr_i && status_hit && (&bus_wdata_i[NPINS-1:0]) && !any_event) |=> !irq_o);

endmodule

// File: tb/tb_pinirq_ctrl.sv
module tb_pinirq_ctrl;

  localparam int CLK_PERIOD = 10;
  localparam logic [7:0] ST = 8'hA0;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] pins = '0;
  logic        wr = 1'b0;
  logic [7:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        irq;

  int n_checks = 0;
  int n_fails  = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pinirq_ctrl dut (
    .clk(clk), .rst_n(rst_n), .pins_i(pins), .bus_wr_i(wr),
    .bus_addr_i(addr), .bus_wdata_i(wdata), .bus_rdata_o(rdata), .irq_o(irq)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fails++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  task automatic write_reg(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    wr = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr = 1'b0;
  endtask

  task automatic read_reg(input logic [7:0] a, output logic [31:0] d);
    addr = a;
    #1;
    d = rdata;
  endtask

  task automatic set_code(input int pin, input logic [3:0] code);
    write_reg(8'(pin * 4), {12'h0, code, 16'h0});
  endtask

  // Change a pin and wait well past the synchroniser latency.
  task automatic drive_pin(input int pin, input logic v);
    @(negedge clk);
    pins[pin] = v;
    repeat (4) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic t_reset();
    logic [31:0] d;
    read_reg(ST, d);        check("R1 status", d, 0);
    check("R1 irq", 32'(irq), 0);
    read_reg(8'h00, d);     check("R1 code pin0", d, 0);
    read_reg(8'h7C, d);     check("R1 code pin31", d, 0);
  endtask

  task automatic t_ctrl_regs();
    logic [31:0] d;
    write_reg(8'h14, 32'hFFFF_FFFF);
    read_reg(8'h14, d);     check("R2 pin5 field only", d, 32'h000F_0000);
    write_reg(8'h7C, 32'h000B_0000);
    read_reg(8'h7C, d);     check("R2 pin31", d, 32'h000B_0000);
    read_reg(8'h10, d);     check("R2 neighbour pin4", d, 0);
    set_code(5, 4'h0);
    set_code(31, 4'h0);
  endtask

  task automatic t_disabled();
    logic [31:0] d;
    set_code(3, 4'h0);
    set_code(4, 4'h5);
    drive_pin(3, 1'b1); drive_pin(4, 1'b1);
    drive_pin(3, 1'b0); drive_pin(4, 1'b0);
    read_reg(ST, d);        check("R3 no flags", d, 0);
    check("R3 irq", 32'(irq), 0);
    set_code(4, 4'h0);
  endtask

  task automatic t_level_low();
    logic [31:0] d;
    set_code(6, 4'h8);
    repeat (3) @(negedge clk);
    read_reg(ST, d);        check("R4 flag while low", d, 32'h40);
    check("R11 irq up", 32'(irq), 1);
    write_reg(ST, 32'h40);
    read_reg(ST, d);        check("R4 clear ignored while low", d, 32'h40);
    drive_pin(6, 1'b1);
    write_reg(ST, 32'h40);
    read_reg(ST, d);        check("R4 cleared after leaving level", d, 0);
    check("R11 irq down", 32'(irq), 0);
    set_code(6, 4'h0);
    drive_pin(6, 1'b0);
  endtask

  task automatic t_level_high();
    logic [31:0] d;
    set_code(7, 4'hC);
    repeat (3) @(negedge clk);
    read_reg(ST, d);        check("R5 quiet while low", d, 0);
    drive_pin(7, 1'b1);
    read_reg(ST, d);        check("R5 flag while high", d, 32'h80);
    drive_pin(7, 1'b0);
    write_reg(ST, 32'h80);
    read_reg(ST, d);        check("R5 cleared", d, 0);
    set_code(7, 4'h0);
  endtask

  task automatic t_rise_latency();
    logic [31:0] d;
    set_code(8, 4'h9);
    @(negedge clk);
    pins[8] = 1'b1;
    repeat (2) @(posedge clk);
    @(negedge clk);
    read_reg(ST, d);        check("R13 not yet after 2 edges", d, 0);
    @(posedge clk);
    @(negedge clk);
    read_reg(ST, d);        check("R13 set after 3 edges", d, 32'h100);
    write_reg(ST, 32'h100);
    drive_pin(8, 1'b0);
    read_reg(ST, d);        check("R6 no flag on fall", d, 0);
    set_code(8, 4'h0);
  endtask

  task automatic t_fall();
    logic [31:0] d;
    set_code(9, 4'hA);
    drive_pin(9, 1'b1);
    read_reg(ST, d);        check("R7 no flag on rise", d, 0);
    drive_pin(9, 1'b0);
    read_reg(ST, d);        check("R7 flag on fall", d, 32'h200);
    write_reg(ST, 32'h200);
    set_code(9, 4'h0);
  endtask

  task automatic t_both();
    logic [31:0] d;
    set_code(10, 4'hB);
    drive_pin(10, 1'b1);
    read_reg(ST, d);        check("R8 rise", d, 32'h400);
    write_reg(ST, 32'h400);
    read_reg(ST, d);        check("R8 cleared", d, 0);
    drive_pin(10, 1'b0);
    read_reg(ST, d);        check("R8 fall", d, 32'h400);
    write_reg(ST, 32'h400);
    set_code(10, 4'h0);
  endtask

  task automatic t_clear();
    logic [31:0] d;
    set_code(8, 4'h9); set_code(9, 4'h9); set_code(10, 4'h9);
    drive_pin(8, 1'b1); drive_pin(9, 1'b1); drive_pin(10, 1'b1);
    read_reg(ST, d);        check("R9 three flags", d, 32'h700);
    write_reg(ST, 32'h0);
    read_reg(ST, d);        check("R9 write 0 no effect", d, 32'h700);
    write_reg(ST, 32'h200);
    read_reg(ST, d);        check("R9 clear one bit", d, 32'h500);
    write_reg(ST, 32'hFFFF_FFFF);
    read_reg(ST, d);        check("R9 clear all", d, 0);
    check("R11 irq after clear all", 32'(irq), 0);
    set_code(8, 4'h0); set_code(9, 4'h0); set_code(10, 4'h0);
    drive_pin(8, 1'b0); drive_pin(9, 1'b0); drive_pin(10, 1'b0);
  endtask

  task automatic t_collision();
    logic [31:0] d;
    set_code(12, 4'hB);
    @(negedge clk);
    pins[12] = 1'b1;
    repeat (2) @(posedge clk);
    @(negedge clk);
    wr = 1'b1; addr = ST; wdata = 32'h1000;
    @(negedge clk);
    wr = 1'b0;
    read_reg(ST, d);        check("R10 set beats clear", d, 32'h1000);
    write_reg(ST, 32'h1000);
    read_reg(ST, d);        check("R10 later clear works", d, 0);
    set_code(12, 4'h0);
    drive_pin(12, 1'b0);
  endtask

  task automatic t_mask();
    logic [31:0] d;
    set_code(11, 4'h9);
    drive_pin(11, 1'b1);
    write_reg(8'h2C, 32'h0);
    read_reg(ST, d);        check("R14 pending kept", d, 32'h800);
    write_reg(ST, 32'h800);
    drive_pin(11, 1'b0);
    drive_pin(11, 1'b1);
    read_reg(ST, d);        check("R14 masked no new flag", d, 0);
    drive_pin(11, 1'b0);
  endtask

  task automatic t_no_false_edge();
    logic [31:0] d;
    drive_pin(13, 1'b1);
    set_code(13, 4'h9);
    repeat (4) @(negedge clk);
    read_reg(ST, d);        check("R12 no stale rise", d, 0);
    set_code(13, 4'h0);
    drive_pin(13, 1'b0);
    set_code(13, 4'hA);
    repeat (4) @(negedge clk);
    read_reg(ST, d);        check("R12 no stale fall", d, 0);
    set_code(13, 4'h0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_ctrl_regs();
    t_disabled();
    t_level_low();
    t_level_high();
    t_rise_latency();
    t_fall();
    t_both();
    t_clear();
    t_collision();
    t_mask();
    t_no_false_edge();
    $display("[TB] %0d tests run, %0d failed", n_checks, n_fails);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    n_checks++;
    n_fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_checks, n_fails);
    $finish;
  end

endmodule